// File: doc/BRIEF.md
# Serial Wiper Up/Down Stepper

This block runs the fine-tuning mode of a two-wire controlled multi-channel digital potentiometer. Once the bus interface has accepted and acknowledged the up/down instruction, it pulses `arm`. From then on the bus clock becomes a step clock and the data line becomes a direction bit. Each complete SCL high pulse moves the wiper register of the chosen channel by one position. The mode ends at the next START or STOP condition. Normal byte framing does not apply while the mode is active.

The block reads the wiper register of the latched channel through a combinational read port. It writes the stepped value back through a one-cycle write strobe. Stepping stops at both ends of the range instead of wrapping. Stepping only ever touches the volatile wiper registers. This block never drives an acknowledge.

Top module: `wiper_stepper`

## Requirements
- R1: After reset, `step_mode` is 0 and `wcr_we` is 0.
- R2: An `arm` pulse with no START/STOP strobe in the same cycle sets `step_mode` to 1 on the next cycle and latches `pot_sel` as the target channel. Later changes of `pot_sel` do not change the target.
- R3: With the mode active, an SCL pulse whose SDA level at the rising edge is 1 produces exactly one write of the read value plus one. `wcr_we` is high for one cycle, in the cycle after the falling SCL edge is seen.
- R4: The same pulse with SDA 0 at the rising edge writes the read value minus one.
- R5: An increment of 255 writes 255, and a decrement of 0 writes 0. The value never wraps.
- R6: The direction is taken only at the SCL rising edge. An SDA change while SCL is high, with no START/STOP strobe, does not alter the step.
- R7: A `start_det` or `stop_det` strobe clears `step_mode` on the next cycle. A pulse in progress at that time writes nothing.
- R8: SCL pulses produce no write while the mode is inactive. A pulse whose rising edge came before `arm` is also not counted.
- R9: `wcr_idx` always equals the latched channel. Registers of other channels are never written.
- R10: In the same cycle, a START/STOP strobe overrides both a falling SCL edge (no write) and an `arm` pulse (the mode stays inactive).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl | input | 1 | Synchronized bus clock level |
| sda | input | 1 | Synchronized bus data level |
| start_det | input | 1 | One-cycle START condition strobe |
| stop_det | input | 1 | One-cycle STOP condition strobe |
| arm | input | 1 | One-cycle strobe: up/down instruction acknowledged |
| pot_sel | input | SEL_W | Channel named by the instruction |
| wcr_rdata | input | DW | Read data of the wiper register at `wcr_idx` |
| wcr_idx | output | SEL_W | Wiper register index for read and write |
| wcr_we | output | 1 | One-cycle write strobe |
| wcr_wdata | output | DW | Stepped value to write |
| step_mode | output | 1 | Up/down mode active |

## Verification
Two events can coincide in one cycle. One is the falling SCL edge that commits a step. The other is a START or STOP strobe that ends the mode. The bench provokes this by driving SCL low and raising `start_det` on the same clock. It judges the result by the scoreboard, which expects no write, and by `step_mode` reading 0 afterwards. A second collision is `arm` together with `start_det`. Here the mode must stay off, and a following SCL pulse must cause no write.

// File: rtl/wstep_pkg.sv
package wstep_pkg;
  typedef enum logic [1:0] {
    WS_IDLE  = 2'd0,
    WS_ARMED = 2'd1,
    WS_PULSE = 2'd2
  } ws_state_t;
endpackage

// File: rtl/wstep_edge.sv
module wstep_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  output logic rise,
  output logic fall
);
  logic scl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) scl_q <= 1'b1;
    else        scl_q <= scl;
  end

  assign rise = scl & ~scl_q;
  assign fall = ~scl & scl_q;
endmodule

// File: rtl/wstep_ctrl.sv
module wstep_ctrl
  import wstep_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic             fall,
  input  logic             sda,
  input  logic             bus_cond,
  input  logic             arm,
  input  logic [SEL_W-1:0] pot_sel,
  output logic [SEL_W-1:0] pot_q,
  output logic             dir_up,
  output logic             commit,
  output logic             active
);
  ws_state_t state, state_nx;

  always_comb begin
    state_nx = state;
    if (bus_cond) begin
      state_nx = WS_IDLE;
    end else begin
      unique case (state)
        WS_IDLE:  if (arm)  state_nx = WS_ARMED;
        WS_ARMED: if (rise) state_nx = WS_PULSE;
        WS_PULSE: if (fall) state_nx = WS_ARMED;
        default:            state_nx = WS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= WS_IDLE;
      pot_q  <= '0;
      dir_up <= 1'b0;
    end else begin
      state <= state_nx;
      if (state == WS_IDLE && arm && !bus_cond) pot_q <= pot_sel;
      if (state == WS_ARMED && rise && !bus_cond) dir_up <= sda;
    end
  end

  assign commit = (state == WS_PULSE) && fall && !bus_cond;
  assign active = (state != WS_IDLE);
endmodule

// File: rtl/wstep_apply.sv
module wstep_apply #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit,
  input  logic          dir_up,
  input  logic [DW-1:0] rd_data,
  output logic          we,
  output logic [DW-1:0] wdata
);
  localparam logic [DW-1:0] TOP = {DW{1'b1}};
  localparam logic [DW-1:0] BOT = '0;

  function automatic logic [DW-1:0] sat_step(input logic [DW-1:0] cur,
                                             input logic up);
    if (up) return (cur == TOP) ? TOP : cur + 1'b1;
    else    return (cur == BOT) ? BOT : cur - 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we    <= 1'b0;
      wdata <= '0;
    end else begin
      we <= commit;
      if (commit) wdata <= sat_step(rd_data, dir_up);
    end
  end
endmodule

// File: rtl/wiper_stepper.sv
module wiper_stepper #(
  parameter int DW    = 8,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl,
  input  logic             sda,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic             arm,
  input  logic [SEL_W-1:0] pot_sel,
  input  logic [DW-1:0]    wcr_rdata,
  output logic [SEL_W-1:0] wcr_idx,
  output logic             wcr_we,
  output logic [DW-1:0]    wcr_wdata,
  output logic             step_mode
);
  logic scl_rise, scl_fall, bus_cond, step_up, commit_req;

  assign bus_cond = start_det | stop_det;

  wstep_edge u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .scl  (scl),
    .rise (scl_rise),
    .fall (scl_fall)
  );

  wstep_ctrl #(.SEL_W(SEL_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .rise    (scl_rise),
    .fall    (scl_fall),
    .sda     (sda),
    .bus_cond(bus_cond),
    .arm     (arm),
    .pot_sel (pot_sel),
    .pot_q   (wcr_idx),
    .dir_up  (step_up),
    .commit  (commit_req),
    .active  (step_mode)
  );

  wstep_apply #(.DW(DW)) u_apply (
    .clk    (clk),
    .rst_n  (rst_n),
    .commit (commit_req),
    .dir_up (step_up),
    .rd_data(wcr_rdata),
    .we     (wcr_we),
    .wdata  (wcr_wdata)
  );
endmodule

// File: rtl/wiper_stepper_chk.sv
module wiper_stepper_chk #(
  parameter int DW    = 8,
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_det,
  input logic             stop_det,
  input logic             arm,
  input logic             step_mode,
  input logic             wcr_we,
  input logic [DW-1:0]    wcr_wdata,
  input logic [DW-1:0]    wcr_rdata,
  input logic [SEL_W-1:0] wcr_idx,
  input logic             scl_fall,
  input logic             step_up
);
  a_r1_write_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
    wcr_we |-> $past(step_mode));

  a_r2_arm_enters: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && !start_det && !stop_det) |=> step_mode);

  a_r3_write_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    wcr_we |-> $past(scl_fall));

  a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    wcr_we |=> !wcr_we);

  a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    wcr_we |-> ($past(step_up) ? (wcr_wdata >= $past(wcr_rdata))
                               : (wcr_wdata <= $past(wcr_rdata))));

  a_r7_cond_exits: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det || stop_det) |=> (!step_mode && !wcr_we));

  a_r9_target_held: assert property (@(posedge clk) disable iff (!rst_n)
    (step_mode && $past(step_mode)) |-> $stable(wcr_idx));
endmodule

bind wiper_stepper wiper_stepper_chk #(.DW(DW), .SEL_W(SEL_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_det(start_det),
  .stop_det (stop_det),
  .arm      (arm),
  .step_mode(step_mode),
  .wcr_we   (wcr_we),
  .wcr_wdata(wcr_wdata),
  .wcr_rdata(wcr_rdata),
  .wcr_idx  (wcr_idx),
  .scl_fall (scl_fall),
  .step_up  (step_up)
);

// File: tb/wiper_stepper_test.sv
module wiper_stepper_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1, sda = 1'b1;
  logic       start_det = 1'b0, stop_det = 1'b0, arm = 1'b0;
  logic [1:0] pot_sel = 2'd0;
  logic [7:0] wcr_rdata;
  logic [1:0] wcr_idx;
  logic       wcr_we;
  logic [7:0] wcr_wdata;
  logic       step_mode;

  int vecs = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [7:0] regf [4];
  logic [7:0] model [4];
  logic [1:0] cur_pot;
  logic [9:0] exp_q [$];
  string      tag_q [$];

  always #10 clk = ~clk;

  wiper_stepper uut (
    .clk(clk), .rst_n(rst_n), .scl(scl), .sda(sda),
    .start_det(start_det), .stop_det(stop_det), .arm(arm),
    .pot_sel(pot_sel), .wcr_rdata(wcr_rdata), .wcr_idx(wcr_idx),
    .wcr_we(wcr_we), .wcr_wdata(wcr_wdata), .step_mode(step_mode)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      regf[0] <= 8'h10; regf[1] <= 8'hFE; regf[2] <= 8'h01; regf[3] <= 8'h80;
    end else if (wcr_we) begin
      regf[wcr_idx] <= wcr_wdata;
    end
  end
  assign wcr_rdata = regf[wcr_idx];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && wcr_we) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8 unexpected write", {wcr_idx, wcr_wdata}, 0);
      end else begin
        logic [9:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({wcr_idx, wcr_wdata} == e, t, {wcr_idx, wcr_wdata}, e);
      end
    end
  end

  function automatic logic [7:0] ref_step(input logic [7:0] v, input logic up);
    int n;
    n = up ? int'(v) + 1 : int'(v) - 1;
    if (n > 255) n = 255;
    if (n < 0) n = 0;
    return n[7:0];
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe_start();
    @(negedge clk) start_det = 1'b1;
    @(negedge clk) start_det = 1'b0;
  endtask

  task automatic strobe_stop();
    @(negedge clk) stop_det = 1'b1;
    @(negedge clk) stop_det = 1'b0;
  endtask

  task automatic arm_pot(input logic [1:0] p);
    @(negedge clk) begin pot_sel = p; arm = 1'b1; end
    @(negedge clk) arm = 1'b0;
    cur_pot = p;
    chk(step_mode == 1'b1, "R2 mode entered", step_mode, 1);
  endtask

  task automatic pulse(input logic up, input bit flip, input bit counts, input string tag);
    @(negedge clk) sda = up;
    idle(1);
    scl = 1'b1;
    idle(2);
    if (flip) sda = ~up;
    idle(2);
    if (counts) begin
      model[cur_pot] = ref_step(model[cur_pot], up);
      exp_q.push_back({cur_pot, model[cur_pot]});
      tag_q.push_back(tag);
    end
    scl = 1'b0;
    idle(4);
  endtask

  initial begin
    model[0] = 8'h10; model[1] = 8'hFE; model[2] = 8'h01; model[3] = 8'h80;
    cur_pot = 2'd0;
    idle(4);
    rst_n = 1'b1;
    idle(1);
    chk(step_mode == 1'b0, "R1 reset mode", step_mode, 0);
    chk(wcr_we == 1'b0, "R1 reset write", wcr_we, 0);

    pulse(1'b1, 1'b0, 1'b0, "R8");
    chk(step_mode == 1'b0, "R8 inactive pulse", step_mode, 0);

    strobe_start();
    arm_pot(2'd1);
    pulse(1'b1, 1'b0, 1'b1, "R3 increment");
    pulse(1'b1, 1'b0, 1'b1, "R5 top saturate");
    @(negedge clk) pot_sel = 2'd3;
    pulse(1'b0, 1'b0, 1'b1, "R9 latched target");
    strobe_stop();
    chk(step_mode == 1'b0, "R7 stop exits", step_mode, 0);

    strobe_start();
    arm_pot(2'd2);
    pulse(1'b0, 1'b0, 1'b1, "R4 decrement");
    pulse(1'b0, 1'b0, 1'b1, "R5 bottom saturate");
    @(negedge clk) begin sda = 1'b1; scl = 1'b1; end
    idle(2);
    stop_det = 1'b1;
    @(negedge clk) stop_det = 1'b0;
    scl = 1'b0;
    idle(3);
    chk(step_mode == 1'b0, "R7 cancel mid pulse", step_mode, 0);
    chk(regf[2] == model[2], "R7 no write", regf[2], model[2]);

    strobe_start();
    @(negedge clk) scl = 1'b1;
    arm_pot(2'd0);
    idle(2);
    scl = 1'b0;
    idle(3);
    chk(regf[0] == 8'h10, "R8 early rise ignored", regf[0], 8'h10);
    pulse(1'b1, 1'b0, 1'b1, "R3 increment pot0");
    pulse(1'b1, 1'b1, 1'b1, "R6 sda change while high");

    @(negedge clk) begin sda = 1'b0; scl = 1'b1; end
    idle(3);
    scl = 1'b0; start_det = 1'b1;
    @(negedge clk) start_det = 1'b0;
    idle(2);
    chk(step_mode == 1'b0, "R10 cond beats fall mode", step_mode, 0);
    chk(regf[0] == model[0], "R10 cond beats fall write", regf[0], model[0]);

    @(negedge clk) begin arm = 1'b1; start_det = 1'b1; pot_sel = 2'd3; end
    @(negedge clk) begin arm = 1'b0; start_det = 1'b0; end
    chk(step_mode == 1'b0, "R10 cond beats arm", step_mode, 0);
    pulse(1'b1, 1'b0, 1'b0, "R10");

    idle(4);
    chk(exp_q.size() == 0, "R3 writes missing", exp_q.size(), 0);
    for (int i = 0; i < 4; i++)
      chk(regf[i] == model[i], "R9 final register", regf[i], model[i]);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      vecs++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end
endmodule